// File: doc/BRIEF.md
# H-Bridge Switch Command Logic

This block turns the control inputs of a four-switch H-bridge into gate enables for the two high-side and two low-side switches. A disable pin, a PWM pin and a direction pin select between forward drive, reverse drive, high-side freewheeling and the fully-off state. While PWM is low, the bridge keeps the high side of the active direction on and opens the low side. Load current then circulates through the high-side path. The disable pin is synchronized and glitch-filtered before use. A fault-shutdown input overrides everything else.

A register-style override lets a serial host replace the pins with its own enable, direction and PWM values. The override can only be armed while disable, PWM and direction are all low. Any later movement on those pins hands control back to the pins. Each high-side switch has an overcurrent comparator flag. If a flag stays up past a blanking window, the low side across the load is forced off, so the current decays by freewheeling. Successive chopper transitions on one side are held at least a minimum number of cycles apart. All timing is counted in clock cycles.

Top module: `hbridge_ctrl`

## Requirements
- R1: During reset all four gate enables are 0 and both tristate indications are 1. The filtered disable starts in the disabled state.
- R2: While the filtered disable is high and the override is not armed, all four switches are off and both outputs report tristate, for any PWM or direction value.
- R3: With disable low and PWM=1, the gates take their new value one clock edge after the inputs are sampled. Direction=1 turns on HS1 and LS2 (OUT1 high, OUT2 low). Direction=0 turns on HS2 and LS1.
- R4: With disable low and PWM=0, only the high side of the selected direction is on: HS1 for direction=1, HS2 for direction=0. The other output reports tristate.
- R5: The disable pin goes through a SYNC_STAGES flop synchronizer and a filter. A new level is accepted only after DIS_FILT consecutive agreeing cycles, so a pulse shorter than DIS_FILT cycles has no effect. A stable new level reaches the gates on the SYNC_STAGES+DIS_FILT+1-th clock edge after it is first sampled.
- R6: If a high-side overcurrent flag is held for BLANK_CYC+1 consecutive sampled cycles, the opposite low side turns off on the next edge (flag 1 forces LS2, flag 2 forces LS1). A shorter flag pulse leaves the gates unchanged.
- R7: When the flag drops and the spacing window has already expired, the forced low side follows the inputs again on the second edge after the drop.
- R8: Two chopper transitions on one side are at least TRANS_CYC+1 clock edges apart. A release requested earlier than that is deferred until the window ends.
- R9: A write that sets the override select is ignored unless filtered disable, PWM and direction are all low when it is sampled.
- R10: While the override is armed, its direction and PWM bits replace the pins. An override enable of 0 turns all four switches off.
- R11: A change on the PWM pin, the direction pin or the filtered disable clears the override. The pins take effect again one edge later.
- R12: A high fault input turns all four switches off on the next edge, with priority over every other input.
- R13: HS1 and LS1 are never on together, and neither are HS2 and LS2, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dis_pin | input | 1 | Bridge disable, asynchronous |
| pwm_pin | input | 1 | Duty-cycle input |
| dir_pin | input | 1 | Direction input, 1 = forward |
| fault | input | 1 | Fault shutdown, highest priority |
| oc_hs1 | input | 1 | Overcurrent flag of HS1 |
| oc_hs2 | input | 1 | Overcurrent flag of HS2 |
| ctl_we | input | 1 | Override register write strobe |
| ctl_sel | input | 1 | Override select bit written |
| ctl_en | input | 1 | Override enable bit written |
| ctl_dir | input | 1 | Override direction bit written |
| ctl_pwm | input | 1 | Override PWM bit written |
| hs1_on | output | 1 | HS1 gate enable |
| ls1_on | output | 1 | LS1 gate enable |
| hs2_on | output | 1 | HS2 gate enable |
| ls2_on | output | 1 | LS2 gate enable |
| out1_z | output | 1 | OUT1 is high-impedance |
| out2_z | output | 1 | OUT2 is high-impedance |

## Verification
The truth table is exercised with random PWM and direction values drawn every cycle. This separates drive from freewheel and forward from reverse, and random fault pulses show that shutdown wins over any combination. Directed disable pulses just shorter than the filter, and a stable level timed to the exact edge, separate correct filtering from a pass-through or an off-by-one latency. For the chopper, three cases are compared: a flag one cycle short of the blanking window, a release inside the spacing window, and a release after it. Together they pin the blanking count and the spacing delay on both sides. Override writes made with the pins low and with PWM high, and a later pin change, show arming, gating and cancellation.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DIS_FILT    = 4,
  parameter int BLANK_CYC   = 6,
  parameter int TRANS_CYC   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_pin,
  input  logic pwm_pin,
  input  logic dir_pin,
  input  logic fault,
  input  logic oc_hs1,
  input  logic oc_hs2,
  input  logic ctl_we,
  input  logic ctl_sel,
  input  logic ctl_en,
  input  logic ctl_dir,
  input  logic ctl_pwm,
  output logic hs1_on,
  output logic ls1_on,
  output logic hs2_on,
  output logic ls2_on,
  output logic out1_z,
  output logic out2_z
);
  localparam int FW = $clog2(DIS_FILT + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int TW = $clog2(TRANS_CYC + 1);

  // disable synchronizer and glitch filter
  logic [SYNC_STAGES-1:0] dsync;
  logic [FW-1:0] fcnt;
  logic dis_f;
  wire dis_s = dsync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsync <= '1;
      fcnt  <= '0;
      dis_f <= 1'b1;
    end else begin
      dsync <= {dsync[SYNC_STAGES-2:0], dis_pin};
      if (dis_s == dis_f) fcnt <= '0;
      else if (fcnt == FW'(DIS_FILT - 1)) begin
        dis_f <= dis_s;
        fcnt  <= '0;
      end else fcnt <= fcnt + 1'b1;
    end
  end

  // chopper: index 0 watches HS1 and cuts LS2, index 1 watches HS2 and cuts LS1
  wire  [1:0] oc = {oc_hs2, oc_hs1};
  logic [1:0] chop;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic [BW-1:0] bcnt;
    logic [TW-1:0] tcnt;
    logic chop_r;
    wire  over = oc[i] && (bcnt == BW'(BLANK_CYC));
    wire  ok   = (tcnt == TW'(TRANS_CYC));
    wire  nxt  = ok ? (chop_r ? oc[i] : over) : chop_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bcnt   <= '0;
        tcnt   <= TW'(TRANS_CYC);
        chop_r <= 1'b0;
      end else begin
        if (!oc[i]) bcnt <= '0;
        else if (bcnt != BW'(BLANK_CYC)) bcnt <= bcnt + 1'b1;
        chop_r <= nxt;
        if (nxt != chop_r) tcnt <= '0;
        else if (!ok) tcnt <= tcnt + 1'b1;
      end
    end
    assign chop[i] = chop_r;
  end

  // serial override
  logic sel, ov_en, ov_dir, ov_pwm, pwm_q, dir_q, disf_q;
  wire pin_chg  = (pwm_pin != pwm_q) || (dir_pin != dir_q) || (dis_f != disf_q);
  wire pins_low = !dis_f && !pwm_pin && !dir_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sel, ov_en, ov_dir, ov_pwm} <= '0;
      {pwm_q, dir_q} <= '0;
      disf_q <= 1'b1;
    end else begin
      pwm_q  <= pwm_pin;
      dir_q  <= dir_pin;
      disf_q <= dis_f;
      if (ctl_we) {ov_en, ov_dir, ov_pwm} <= {ctl_en, ctl_dir, ctl_pwm};
      if (pin_chg) sel <= 1'b0;
      else if (ctl_we) sel <= ctl_sel && pins_low;
    end
  end

  // bridge truth table
  wire off = fault || (sel ? !ov_en : dis_f);
  wire d   = sel ? ov_dir : dir_pin;
  wire p   = sel ? ov_pwm : pwm_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {hs1_on, ls1_on, hs2_on, ls2_on} <= '0;
    else begin
      hs1_on <= !off && d;
      ls2_on <= !off && d && p && !chop[0];
      hs2_on <= !off && !d;
      ls1_on <= !off && !d && p && !chop[1];
    end
  end

  assign out1_z = !hs1_on && !ls1_on;
  assign out2_z = !hs2_on && !ls2_on;

  assert_no_shoot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs1_on && ls1_on) && !(hs2_on && ls2_on));
  assert_fault_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !(hs1_on || ls1_on || hs2_on || ls2_on));
  assert_dis_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_f && !sel) |=> (out1_z && out2_z));
  assert_chop_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chop[0] |=> !ls2_on);
  assert_arm_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(pins_low));
  assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && pin_chg) |=> !sel);
endmodule

// File: tb/sim_hbridge_ctrl.sv
module sim_hbridge_ctrl;
  localparam int PERIOD = 10;
  localparam int SYNC = 2, FILT = 4, BLANK = 6, TRANS = 20;

  logic clk = 0, rst_n = 0;
  logic dis_pin = 1, pwm_pin = 0, dir_pin = 0, fault = 0, oc_hs1 = 0, oc_hs2 = 0;
  logic ctl_we = 0, ctl_sel = 0, ctl_en = 0, ctl_dir = 0, ctl_pwm = 0;
  logic hs1_on, ls1_on, hs2_on, ls2_on, out1_z, out2_z;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  hbridge_ctrl #(.SYNC_STAGES(SYNC), .DIS_FILT(FILT), .BLANK_CYC(BLANK), .TRANS_CYC(TRANS)) u0 (
    .clk, .rst_n, .dis_pin, .pwm_pin, .dir_pin, .fault, .oc_hs1, .oc_hs2,
    .ctl_we, .ctl_sel, .ctl_en, .ctl_dir, .ctl_pwm,
    .hs1_on, .ls1_on, .hs2_on, .ls2_on, .out1_z, .out2_z);

  // {hs1, ls1, hs2, ls2, out1_z, out2_z}
  function automatic logic [5:0] expv(logic off, logic d, logic p, logic cut2, logic cut1);
    logic h1, l1, h2, l2;
    h1 = !off && d;  l2 = !off && d && p && !cut2;
    h2 = !off && !d; l1 = !off && !d && p && !cut1;
    return {h1, l1, h2, l2, !h1 && !l1, !h2 && !l2};
  endfunction

  task automatic chk(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {hs1_on, ls1_on, hs2_on, ls2_on, out1_z, out2_z};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic s, logic e, logic d, logic p);
    {ctl_we, ctl_sel, ctl_en, ctl_dir, ctl_pwm} = {1'b1, s, e, d, p};
    tick(1);
    ctl_we = 0;
    tick(1);
  endtask

  initial begin
    int seed;
    bit bad;
    seed = $urandom(32'd91);
    @(negedge clk);
    tick(2);
    chk("R1 reset", 6'b000011);
    rst_n = 1;
    pwm_pin = 1; dir_pin = 1;
    tick(8);
    chk("R2 disabled fwd pins", expv(1, 1, 1, 0, 0));
    for (int k = 0; k < 10; k++) begin
      pwm_pin = 1'($urandom); dir_pin = 1'($urandom);
      tick(1);
      chk("R2 disabled random", 6'b000011);
    end
    // R5 release latency
    pwm_pin = 1; dir_pin = 1;
    tick(1);
    dis_pin = 0;
    tick(SYNC + FILT);
    chk("R5 not yet enabled", 6'b000011);
    tick(1);
    chk("R5 enabled on time", expv(0, 1, 1, 0, 0));
    // R5 glitch shorter than filter
    dis_pin = 1;
    tick(FILT - 1);
    dis_pin = 0;
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      tick(1);
      if ({hs1_on, ls2_on} != 2'b11) bad = 1;
    end
    checks++;
    if (bad) begin errors++; $display("FAIL R5 glitch passed: got gates off, expected on"); end
    // random truth table (R3, R4) with fault pulses (R12)
    for (int k = 0; k < 300; k++) begin
      logic p, d, f;
      p = 1'($urandom); d = 1'($urandom); f = ($urandom % 8) == 0;
      pwm_pin = p; dir_pin = d; fault = f;
      tick(1);
      if (f) chk("R12 fault off", 6'b000011);
      else if (p) chk("R3 drive", expv(0, d, p, 0, 0));
      else chk("R4 freewheel", expv(0, d, p, 0, 0));
    end
    fault = 0;
    // chopper forward: short flag ignored (R6)
    pwm_pin = 1; dir_pin = 1;
    tick(2);
    oc_hs1 = 1;
    bad = 0;
    for (int k = 0; k < BLANK; k++) begin tick(1); if (!ls2_on) bad = 1; end
    oc_hs1 = 0;
    tick(3);
    if (!ls2_on) bad = 1;
    checks++;
    if (bad) begin errors++; $display("FAIL R6 short flag cut LS2: got 0 expected 1"); end
    tick(TRANS + 5);
    // full blanking then cut (R6)
    oc_hs1 = 1;
    tick(BLANK + 1);
    chk("R6 inside blanking", expv(0, 1, 1, 0, 0));
    tick(1);
    chk("R6 cut after blanking", expv(0, 1, 1, 1, 0));
    // early release deferred (R8)
    oc_hs1 = 0;
    tick(TRANS);
    chk("R8 spacing holds cut", expv(0, 1, 1, 1, 0));
    tick(1);
    chk("R8 release after spacing", expv(0, 1, 1, 0, 0));
    // reverse chop with late release (R6, R7)
    dir_pin = 0;
    tick(TRANS + 5);
    oc_hs2 = 1;
    tick(BLANK + 2);
    chk("R6 reverse cut LS1", expv(0, 0, 1, 0, 1));
    tick(TRANS + 5);
    oc_hs2 = 0;
    tick(1);
    chk("R7 one edge after drop", expv(0, 0, 1, 0, 1));
    tick(1);
    chk("R7 released", expv(0, 0, 1, 0, 0));
    // override
    pwm_pin = 0; dir_pin = 0;
    tick(2);
    chk("R4 reverse freewheel", expv(0, 0, 0, 0, 0));
    wr(1, 1, 1, 1);
    chk("R10 override drives forward", expv(0, 1, 1, 0, 0));
    wr(1, 0, 1, 1);
    chk("R10 override enable low", 6'b000011);
    pwm_pin = 1;
    tick(2);
    chk("R11 pin change cancels", expv(0, 0, 1, 0, 0));
    wr(1, 0, 1, 1);
    chk("R9 arm ignored pins busy", expv(0, 0, 1, 0, 0));
    fault = 1;
    tick(1);
    chk("R12 fault final", 6'b000011);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule